// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Generator

This block sits between a processor's interrupt acknowledge request and a pair of interrupt arbitration cores arranged as a primary (master) and a secondary (slave). The slave's interrupt output is routed to master request input 2, which is the cascade line. When the processor asks for a vector, the block snapshots the winning line reported by each core and acknowledges the master's winner. If that winner is the cascade line, it also acknowledges the slave's winner. It then returns an 8-bit vector made from the chosen core's vector base and the line index.

Spurious cases follow fixed rules. If the master has nothing pending, the vector is the master base with line 7, and neither core sees an acknowledge. If the master's winner is the cascade line but the slave has nothing pending, the master is acknowledged and the vector is the slave base with line 7. A vector base keeps only its upper five bits. The lower three vector bits always come from the line index.

The answer appears one clock after the request is accepted. It comes as a single-cycle valid pulse, and the core acknowledge strobes pulse in that same cycle. A request that arrives while an answer is being presented is dropped.

Top module: `casc_ack_vector`

## Requirements
- R1: An acknowledge request sampled high while no answer is being presented is accepted. Exactly one clock later, `vec_valid_o` is high for one cycle.
- R2: A request that is high in the cycle where `vec_valid_o` is high is ignored. Holding the request high continuously therefore gives one answer every second cycle.
- R3: In the answer cycle of an accepted request, `m_ack_o` equals the master pending flag sampled at acceptance. When it is high, `m_ack_line_o` equals the master line sampled at acceptance.
- R4: If the master is pending with a winning line other than 2, the vector is the master base bits [7:3] concatenated with that line, and `s_ack_o` stays low.
- R5: If the master's winner is line 2 and the slave is pending, `s_ack_o` pulses with `s_ack_line_o` equal to the slave line. The vector is the slave base bits [7:3] concatenated with the slave line.
- R6: If the master's winner is line 2 and the slave is not pending, the master is acknowledged on line 2, `s_ack_o` stays low, and the vector is the slave base bits [7:3] with low bits 3'b111.
- R7: If the master is not pending, both acknowledge strobes stay low and the vector is the master base bits [7:3] with low bits 3'b111.
- R8: Bits [2:0] of both base inputs never affect the vector.
- R9: `casc_req_o` (master request input 2) follows `s_int_i` with no delay.
- R10: During reset, and in every cycle without `vec_valid_o`, the vector, both acknowledge strobes and both acknowledge lines are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ack_req_i | input | 1 | Processor interrupt acknowledge request |
| m_pend_i | input | 1 | Master core has a winning request |
| m_line_i | input | 3 | Master core winning line |
| m_base_i | input | 8 | Master programmed vector base byte |
| s_pend_i | input | 1 | Slave core has a winning request |
| s_line_i | input | 3 | Slave core winning line |
| s_base_i | input | 8 | Slave programmed vector base byte |
| s_int_i | input | 1 | Slave core interrupt output |
| casc_req_o | output | 1 | Drive for master request input 2 |
| m_ack_o | output | 1 | Acknowledge strobe to master core |
| m_ack_line_o | output | 3 | Line acknowledged on the master |
| s_ack_o | output | 1 | Acknowledge strobe to slave core |
| s_ack_line_o | output | 3 | Line acknowledged on the slave |
| vec_valid_o | output | 1 | One-cycle vector valid pulse |
| vec_o | output | 8 | Interrupt vector |

## Verification
The hardest cases to reach are the ones where the master wins on the cascade line: a genuine slave request (R5) and a spurious slave (R6). Random stimulus seldom lines up master line 2 with the slave flag in the one sampling cycle. The stimulus therefore forces master line 2 in directed steps, with the slave flag both set and clear. It also runs a biased random phase that picks line 2 about half the time. Back-to-back requests held over several cycles exercise the dropped-request rule. Base bytes with nonzero low bits show that only the line index fills the bottom of the vector.

// File: rtl/casc_ack_pkg.sv
package casc_ack_pkg;

  localparam int LINE_W_DEF    = 3;
  localparam int VEC_W_DEF     = 8;
  localparam int CASC_LINE_DEF = 2;

  // How an accepted acknowledge was resolved
  typedef enum logic [1:0] {
    RES_MASTER     = 2'd0,
    RES_SLAVE      = 2'd1,
    RES_SLAVE_SPUR = 2'd2,
    RES_NONE       = 2'd3
  } res_kind_e;

endpackage

// File: rtl/casc_ack_seq.sv
module casc_ack_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic accept_o,
  output logic present_o
);

  logic present_q;
  logic present_d;

  always_comb begin
    accept_o  = req_i & ~present_q;
    present_d = accept_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= 1'b0;
    end else begin
      present_q <= present_d;
    end
  end

  assign present_o = present_q;

endmodule

// File: rtl/casc_ack_resolve.sv
module casc_ack_resolve
  import casc_ack_pkg::*;
#(
  parameter int LINE_W    = LINE_W_DEF,
  parameter int CASC_LINE = CASC_LINE_DEF
) (
  input  logic              m_pend_i,
  input  logic [LINE_W-1:0] m_line_i,
  input  logic              s_pend_i,
  input  logic [LINE_W-1:0] s_line_i,
  output res_kind_e         kind_o,
  output logic              m_ack_o,
  output logic              s_ack_o,
  output logic [LINE_W-1:0] line_o
);

  localparam logic [LINE_W-1:0] CASC_L = LINE_W'(CASC_LINE);
  localparam logic [LINE_W-1:0] SPUR_L = {LINE_W{1'b1}};

  logic via_casc;

  always_comb begin
    via_casc = m_pend_i && (m_line_i == CASC_L);
    kind_o   = RES_NONE;
    m_ack_o  = 1'b0;
    s_ack_o  = 1'b0;
    line_o   = SPUR_L;
    if (!m_pend_i) begin
      kind_o = RES_NONE;
    end else if (!via_casc) begin
      kind_o  = RES_MASTER;
      m_ack_o = 1'b1;
      line_o  = m_line_i;
    end else if (s_pend_i) begin
      kind_o  = RES_SLAVE;
      m_ack_o = 1'b1;
      s_ack_o = 1'b1;
      line_o  = s_line_i;
    end else begin
      kind_o  = RES_SLAVE_SPUR;
      m_ack_o = 1'b1;
    end
  end

endmodule

// File: rtl/casc_vec_form.sv
module casc_vec_form
  import casc_ack_pkg::*;
#(
  parameter int LINE_W = LINE_W_DEF,
  parameter int VEC_W  = VEC_W_DEF
) (
  input  logic                    en_i,
  input  res_kind_e               kind_i,
  input  logic [VEC_W-1:LINE_W]   m_base_i,
  input  logic [VEC_W-1:LINE_W]   s_base_i,
  input  logic [LINE_W-1:0]       line_i,
  output logic [VEC_W-1:0]        vec_o
);

  logic [VEC_W-1:LINE_W] base_sel;
  logic                  use_slave;

  always_comb begin
    use_slave = (kind_i == RES_SLAVE) || (kind_i == RES_SLAVE_SPUR);
    base_sel  = use_slave ? s_base_i : m_base_i;
  end

  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    if (b < LINE_W) begin : g_low
      assign vec_o[b] = en_i & line_i[b];
    end else begin : g_high
      assign vec_o[b] = en_i & base_sel[b];
    end
  end

endmodule

// File: rtl/casc_ack_vector.sv
module casc_ack_vector
  import casc_ack_pkg::*;
#(
  parameter int LINE_W    = LINE_W_DEF,
  parameter int VEC_W     = VEC_W_DEF,
  parameter int CASC_LINE = CASC_LINE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_req_i,
  input  logic              m_pend_i,
  input  logic [LINE_W-1:0] m_line_i,
  input  logic [VEC_W-1:0]  m_base_i,
  input  logic              s_pend_i,
  input  logic [LINE_W-1:0] s_line_i,
  input  logic [VEC_W-1:0]  s_base_i,
  input  logic              s_int_i,
  output logic              casc_req_o,
  output logic              m_ack_o,
  output logic [LINE_W-1:0] m_ack_line_o,
  output logic              s_ack_o,
  output logic [LINE_W-1:0] s_ack_line_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);

  localparam int SYNC_STAGES = 2;
  localparam int BASE_W      = VEC_W - LINE_W;

  // reset: asserted at once, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  // slave interrupt feeds the master cascade request input
  assign casc_req_o = s_int_i;

  logic accept;
  logic present;

  casc_ack_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_i     (ack_req_i),
    .accept_o  (accept),
    .present_o (present)
  );

  // snapshot of core answers at acceptance
  logic              m_pend_q, m_pend_d;
  logic [LINE_W-1:0] m_line_q, m_line_d;
  logic              s_pend_q, s_pend_d;
  logic [LINE_W-1:0] s_line_q, s_line_d;
  logic [BASE_W-1:0] m_base_q, m_base_d;
  logic [BASE_W-1:0] s_base_q, s_base_d;

  always_comb begin
    m_pend_d = m_pend_q;
    m_line_d = m_line_q;
    s_pend_d = s_pend_q;
    s_line_d = s_line_q;
    m_base_d = m_base_q;
    s_base_d = s_base_q;
    if (accept) begin
      m_pend_d = m_pend_i;
      m_line_d = m_line_i;
      s_pend_d = s_pend_i;
      s_line_d = s_line_i;
      m_base_d = m_base_i[VEC_W-1:LINE_W];
      s_base_d = s_base_i[VEC_W-1:LINE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      m_pend_q <= 1'b0;
      m_line_q <= '0;
      s_pend_q <= 1'b0;
      s_line_q <= '0;
      m_base_q <= '0;
      s_base_q <= '0;
    end else begin
      m_pend_q <= m_pend_d;
      m_line_q <= m_line_d;
      s_pend_q <= s_pend_d;
      s_line_q <= s_line_d;
      m_base_q <= m_base_d;
      s_base_q <= s_base_d;
    end
  end

  res_kind_e         kind;
  logic              m_ack_raw;
  logic              s_ack_raw;
  logic [LINE_W-1:0] sel_line;

  casc_ack_resolve #(
    .LINE_W    (LINE_W),
    .CASC_LINE (CASC_LINE)
  ) u_resolve (
    .m_pend_i (m_pend_q),
    .m_line_i (m_line_q),
    .s_pend_i (s_pend_q),
    .s_line_i (s_line_q),
    .kind_o   (kind),
    .m_ack_o  (m_ack_raw),
    .s_ack_o  (s_ack_raw),
    .line_o   (sel_line)
  );

  casc_vec_form #(
    .LINE_W (LINE_W),
    .VEC_W  (VEC_W)
  ) u_form (
    .en_i     (present),
    .kind_i   (kind),
    .m_base_i (m_base_q),
    .s_base_i (s_base_q),
    .line_i   (sel_line),
    .vec_o    (vec_o)
  );

  always_comb begin
    vec_valid_o  = present;
    m_ack_o      = present & m_ack_raw;
    s_ack_o      = present & s_ack_raw;
    m_ack_line_o = m_ack_o ? m_line_q : '0;
    s_ack_line_o = s_ack_o ? s_line_q : '0;
  end

endmodule

// File: rtl/casc_ack_vector_chk.sv
module casc_ack_vector_chk #(
  parameter int LINE_W    = 3,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_req_i,
  input logic              m_pend_i,
  input logic [LINE_W-1:0] m_line_i,
  input logic [VEC_W-1:0]  m_base_i,
  input logic              m_ack_o,
  input logic [LINE_W-1:0] m_ack_line_o,
  input logic              s_ack_o,
  input logic              vec_valid_o,
  input logic [VEC_W-1:0]  vec_o
);

  // R1
  req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_i && !vec_valid_o) |=> vec_valid_o);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);

  // R3
  master_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (m_ack_o == $past(m_pend_i)));

  // R3
  master_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_ack_o |-> (m_ack_line_o == $past(m_line_i)));

  // R5
  slave_via_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack_o |-> (m_ack_o && m_ack_line_o == LINE_W'(CASC_LINE)));

  // R7
  master_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !m_ack_o) |->
      (vec_o == {$past(m_base_i[VEC_W-1:LINE_W]), {LINE_W{1'b1}}}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (vec_o == '0 && !m_ack_o && !s_ack_o));

endmodule

bind casc_ack_vector casc_ack_vector_chk #(
  .LINE_W    (LINE_W),
  .VEC_W     (VEC_W),
  .CASC_LINE (CASC_LINE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .ack_req_i    (ack_req_i),
  .m_pend_i     (m_pend_i),
  .m_line_i     (m_line_i),
  .m_base_i     (m_base_i),
  .m_ack_o      (m_ack_o),
  .m_ack_line_o (m_ack_line_o),
  .s_ack_o      (s_ack_o),
  .vec_valid_o  (vec_valid_o),
  .vec_o        (vec_o)
);

// File: tb/casc_ack_vector_tb.sv
module casc_ack_vector_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_req = 1'b0;
  logic       m_pend = 1'b0;
  logic [2:0] m_line = '0;
  logic [7:0] m_base = '0;
  logic       s_pend = 1'b0;
  logic [2:0] s_line = '0;
  logic [7:0] s_base = '0;
  logic       s_int = 1'b0;
  logic       casc_req, m_ack, s_ack, vec_valid;
  logic [2:0] m_ack_line, s_ack_line;
  logic [7:0] vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  casc_ack_vector u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_req_i    (ack_req),
    .m_pend_i     (m_pend),
    .m_line_i     (m_line),
    .m_base_i     (m_base),
    .s_pend_i     (s_pend),
    .s_line_i     (s_line),
    .s_base_i     (s_base),
    .s_int_i      (s_int),
    .casc_req_o   (casc_req),
    .m_ack_o      (m_ack),
    .m_ack_line_o (m_ack_line),
    .s_ack_o      (s_ack),
    .s_ack_line_o (s_ack_line),
    .vec_valid_o  (vec_valid),
    .vec_o        (vec)
  );

  // reference model state
  int    e_valid = 0, e_vec = 0, e_mack = 0, e_mline = 0, e_sack = 0, e_sline = 0;
  string e_tag = "R10";
  string v_tag = "R10";

  always @(posedge clk) begin
    int mb_hi, sb_hi;
    if (!rst_n) begin
      e_valid = 0; e_vec = 0; e_mack = 0; e_mline = 0; e_sack = 0; e_sline = 0;
      e_tag = "R10"; v_tag = "R10";
    end else if (ack_req && e_valid == 0) begin
      mb_hi = (m_base / 8) * 8;
      sb_hi = (s_base / 8) * 8;
      e_valid = 1; v_tag = "R1";
      e_mack = 0; e_mline = 0; e_sack = 0; e_sline = 0;
      if (!m_pend) begin
        e_vec = mb_hi + 7; e_tag = "R7";
      end else if (m_line != 3'd2) begin
        e_mack = 1; e_mline = m_line;
        e_vec = mb_hi + m_line; e_tag = "R4";
      end else if (s_pend) begin
        e_mack = 1; e_mline = 2; e_sack = 1; e_sline = s_line;
        e_vec = sb_hi + s_line; e_tag = "R5";
      end else begin
        e_mack = 1; e_mline = 2;
        e_vec = sb_hi + 7; e_tag = "R6";
      end
    end else begin
      v_tag = (ack_req && e_valid == 1) ? "R2" : "R10";
      e_valid = 0; e_vec = 0; e_mack = 0; e_mline = 0; e_sack = 0; e_sline = 0;
      e_tag = "R10";
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(v_tag, "vec_valid", vec_valid, e_valid);
      chk(e_tag, "vec", vec, e_vec);
      chk((e_tag == "R10") ? "R10" : "R3", "m_ack", m_ack, e_mack);
      chk((e_tag == "R10") ? "R10" : "R3", "m_ack_line", m_ack_line, e_mline);
      chk((e_tag == "R10") ? "R10" : "R5", "s_ack", s_ack, e_sack);
      chk((e_tag == "R10") ? "R10" : "R5", "s_ack_line", s_ack_line, e_sline);
      chk("R9", "casc_req", casc_req, s_int);
    end
  end

  task automatic drive(input bit req, input bit mp, input int ml, input int mb,
                       input bit sp, input int sl, input int sb, input bit si);
    @(posedge clk);
    #5;
    ack_req = req; m_pend = mp; m_line = 3'(ml); m_base = 8'(mb);
    s_pend = sp; s_line = 3'(sl); s_base = 8'(sb); s_int = si;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state, with inputs active
    drive(1, 1, 3, 8'h57, 1, 4, 8'h6F, 1);
    #5;
    chk("R10", "reset vec_valid", vec_valid, 0);
    chk("R10", "reset vec", vec, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (5) drive(0, 0, 0, 0, 0, 0, 0, 0);

    // R4 master line, base low bits nonzero (R8)
    drive(1, 1, 5, 8'h47, 0, 0, 8'h9B, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    // R5 cascade with slave pending
    drive(1, 1, 2, 8'h20, 1, 6, 8'h7D, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    // R6 cascade with slave spurious
    drive(1, 1, 2, 8'h20, 0, 3, 8'hA6, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    // R7 master spurious
    drive(1, 0, 4, 8'hC3, 1, 1, 8'h11, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    // R2 request held high across several cycles
    repeat (6) drive(1, 1, 1, 8'h08, 0, 0, 8'h70, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    // R9 cascade wire toggling without requests
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0);

    // biased random phase
    for (int i = 0; i < 600; i++) begin
      int ml;
      ml = ($urandom % 2 == 0) ? 2 : int'($urandom % 8);
      drive(($urandom % 3) != 0, ($urandom % 5) != 0, ml, int'($urandom % 256),
            $urandom % 2 == 1, int'($urandom % 8), int'($urandom % 256),
            $urandom % 2 == 1);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule